// File: doc/BRIEF.md
# CAN Base-Frame Transmitter with Bus Arbitration

This block sends classical CAN frames with an 11-bit identifier. It sends one bit for each bit-time strobe. A request carries the identifier, the remote flag, the length code and up to eight payload bytes. The request is taken over a valid/ready handshake. The block keeps the accepted frame until a transmission attempt completes cleanly. Every attempt ends with a one-cycle completion pulse and a status code. After a failed attempt the same frame goes out again at the next idle opportunity, with no further action from the requester.

On each strobe the block compares the level it is driving with the bus level sampled for that bit. The bus is a wired-AND: dominant is 0 and wins over recessive 1.

- Inside the identifier and remote-flag positions, reading dominant while sending recessive means another node has a lower identifier. The block then falls silent without signalling an error.
- In the acknowledge slot, the block sends recessive and requires some receiver to pull the bus dominant.
- Anywhere else, any disagreement between the sent and read levels ends the attempt as a bit error.

The output is the raw, unstuffed bit stream. A flag beside it tells a downstream stuffing stage which bits fall in the stuffed region.

Back-pressure: `req_ready` is high only while no frame is held. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low through every retry and returns high one cycle after the successful completion pulse. The requester may change the request fields freely while `req_ready` is low.

Top module: `can_frame_tx`

## Requirements
- R1: After reset, `tx_bit` is recessive (1), `tx_stuffable`, `tx_busy` and `done_valid` are 0, and `req_ready` is 1.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` then stays low, and the accepted frame is held unchanged, until an attempt succeeds.
- R3: An attempt starts only on a `bit_tick` while a frame is held and `bus_idle` is high. With `bus_idle` low, `tx_bit` stays 1 and `tx_busy` stays 0. The first bit of an attempt is a dominant start bit.
- R4: After the start bit the stream carries, in this order:
  - the identifier, MSB first;
  - the remote flag;
  - two dominant reserved bits;
  - the 4-bit length code, MSB first;
  - the payload, byte 0 taken from `req_data[63:56]`, each byte MSB first.
  The number of payload bytes is min(length code, 8), and zero when the remote flag is set.
- R5: After the payload come 15 check bits, MSB first. They are the remainder over all bits from the start bit through the last payload bit, with generator 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1) and a zero initial value.
- R6: After the check bits the block sends 10 recessive bits: a delimiter, the acknowledge slot, a second delimiter and 7 end-of-frame bits.
- R7: `tx_stuffable` is 1 from the start bit through the last check bit, and 0 on every other bit.
- R8: If a recessive identifier or remote-flag bit is read back dominant, the attempt ends at that strobe. `done_status` is 1 (arbitration lost), and `tx_bit` returns to 1.
- R9: Any other disagreement between the sent and read levels, outside the acknowledge slot, ends the attempt with `done_status` 2 (bit error).
- R10: A recessive reading in the acknowledge slot ends the attempt with `done_status` 3 (no acknowledge).
- R11: When the last end-of-frame bit passes cleanly, `done_valid` pulses with `done_status` 0. `req_ready` is 1 in the following cycle.
- R12: After a failed attempt the held frame is sent again, bit for bit, starting at the next strobe with `bus_idle` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Request can be accepted (no frame held) |
| req_id | input | 11 | Frame identifier |
| req_rtr | input | 1 | Remote flag |
| req_dlc | input | 4 | Length code |
| req_data | input | 64 | Payload, byte 0 in bits 63:56 |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_bit | input | 1 | Sampled bus level for the current bit |
| bus_idle | input | 1 | Bus integration reports the bus free |
| tx_bit | output | 1 | Unstuffed level to drive this bit time |
| tx_stuffable | output | 1 | Current bit lies in the stuffed region |
| tx_busy | output | 1 | An attempt is in progress |
| done_valid | output | 1 | One-cycle attempt completion pulse |
| done_status | output | 2 | 0 ok, 1 arbitration lost, 2 bit error, 3 no acknowledge |

## Verification
A strobe is captured on a clock edge, and that edge both judges the current bit and moves `tx_bit` and `tx_stuffable` to the next bit. So the next bit, and any completion pulse with its status, are due in the cycle right after the capturing edge. `req_ready` rises one cycle later still. The bench holds each strobe for one cycle and reads all outputs at the falling edge after the capture. It then lets a quiet cycle pass before it reads `tx_bit` for the next strobe, so every comparison lands on the cycle where the result is due. Expected streams, check bits and the position of the failing strobe are all worked out in the bench from the frame fields.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  typedef enum logic [3:0] {
    F_IDLE, F_SOF, F_ID, F_RTR, F_CTRL, F_DATA,
    F_CRC, F_CRCDEL, F_ACK, F_ACKDEL, F_EOF
  } fld_e;

  typedef enum logic [1:0] {
    TX_OK       = 2'd0,
    TX_ARB_LOST = 2'd1,
    TX_BIT_ERR  = 2'd2,
    TX_ACK_ERR  = 2'd3
  } txst_e;

  function automatic logic [CRC_W-1:0] crc_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    crc_next = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/can_tx_crc.sv
module can_tx_crc
  import can_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic feed_en,
  input  logic feed_bit,
  input  logic shift_en,
  output logic msb
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= '0;
    else if (clr)      crc_q <= '0;
    else if (feed_en)  crc_q <= crc_next(crc_q, feed_bit);
    else if (shift_en) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign msb = crc_q[CRC_W-1];

  AST_CRC_FEED_XOR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) feed_en |-> !shift_en and !clr); // R5
endmodule

// File: rtl/can_tx_req_hold.sv
module can_tx_req_hold #(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int DATA_W    = 64,
  parameter int MAX_BYTES = 8,
  localparam int NB_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_rtr,
  input  logic [DLC_W-1:0]  req_dlc,
  input  logic [DATA_W-1:0] req_data,
  input  logic              success,
  output logic              pending,
  output logic [ID_W-1:0]   h_id,
  output logic              h_rtr,
  output logic [DLC_W-1:0]  h_dlc,
  output logic [DATA_W-1:0] h_data,
  output logic [NB_W-1:0]   h_nbytes
);
  localparam logic [DLC_W-1:0] MAXB = DLC_W'(MAX_BYTES);
  logic accept;

  assign req_ready = !pending;
  assign accept    = req_valid && !pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      h_id    <= '0;
      h_rtr   <= 1'b0;
      h_dlc   <= '0;
      h_data  <= '0;
    end else begin
      if (accept) begin
        pending <= 1'b1;
        h_id    <= req_id;
        h_rtr   <= req_rtr;
        h_dlc   <= req_dlc;
        h_data  <= req_data;
      end else if (success) begin
        pending <= 1'b0;
      end
    end
  end

  always_comb begin
    if (h_rtr)             h_nbytes = '0;
    else if (h_dlc > MAXB) h_nbytes = NB_W'(MAX_BYTES);
    else                   h_nbytes = NB_W'(h_dlc);
  end

  AST_DROP_ONLY_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n) $fell(pending) |-> $past(success)); // R12
  AST_HELD_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n) pending && !success |=> $stable(h_id) && $stable(h_data)); // R2
endmodule

// File: rtl/can_tx_mon.sv
module can_tx_mon
  import can_tx_pkg::*;
(
  input  logic  tick,
  input  fld_e  field,
  input  logic  tx_bit,
  input  logic  bus_bit,
  output logic  fail,
  output txst_e fail_status
);
  always_comb begin
    fail        = 1'b0;
    fail_status = TX_OK;
    if (tick) begin
      case (field)
        F_IDLE: ;
        F_ID, F_RTR: begin
          if (tx_bit && !bus_bit) begin
            fail        = 1'b1;
            fail_status = TX_ARB_LOST;
          end else if (!tx_bit && bus_bit) begin
            fail        = 1'b1;
            fail_status = TX_BIT_ERR;
          end
        end
        F_ACK: begin
          if (bus_bit) begin
            fail        = 1'b1;
            fail_status = TX_ACK_ERR;
          end
        end
        default: begin
          if (tx_bit != bus_bit) begin
            fail        = 1'b1;
            fail_status = TX_BIT_ERR;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/can_tx_seq.sv
module can_tx_seq
  import can_tx_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int DATA_W    = 64,
  parameter int MAX_BYTES = 8,
  parameter int EOF_LEN   = 7,
  localparam int NB_W     = $clog2(MAX_BYTES + 1),
  localparam int SR_W     = ID_W + 1 + 2 + DLC_W + DATA_W,
  localparam int CNT_W    = $clog2(DATA_W + CRC_W + ID_W + EOF_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_ok,
  input  logic [ID_W-1:0]   h_id,
  input  logic              h_rtr,
  input  logic [DLC_W-1:0]  h_dlc,
  input  logic [DATA_W-1:0] h_data,
  input  logic [NB_W-1:0]   h_nbytes,
  input  logic              fail,
  input  txst_e             fail_status,
  input  logic              crc_msb,
  output fld_e              field,
  output logic              busy,
  output logic              tx_bit,
  output logic              stuffable,
  output logic              crc_clr,
  output logic              crc_feed,
  output logic              crc_shift,
  output logic              done_valid,
  output txst_e             done_status
);
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] data_bits;
  logic             step;
  logic             start;

  assign data_bits = CNT_W'(h_nbytes) << 3;
  assign step      = tick && !fail;
  assign start     = tick && (field == F_IDLE) && start_ok && !done_valid;
  assign busy      = (field != F_IDLE);

  always_comb begin
    case (field)
      F_SOF:                     tx_bit = 1'b0;
      F_ID, F_RTR, F_CTRL, F_DATA: tx_bit = sr[SR_W-1];
      F_CRC:                     tx_bit = crc_msb;
      default:                   tx_bit = 1'b1;
    endcase
  end

  always_comb begin
    case (field)
      F_SOF, F_ID, F_RTR, F_CTRL, F_DATA, F_CRC: stuffable = 1'b1;
      default:                                   stuffable = 1'b0;
    endcase
  end

  assign crc_clr   = start;
  assign crc_feed  = step && (field inside {F_SOF, F_ID, F_RTR, F_CTRL, F_DATA});
  assign crc_shift = step && (field == F_CRC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      field       <= F_IDLE;
      sr          <= '0;
      cnt         <= '0;
      done_valid  <= 1'b0;
      done_status <= TX_OK;
    end else begin
      done_valid <= 1'b0;
      if (tick && fail) begin
        field       <= F_IDLE;
        done_valid  <= 1'b1;
        done_status <= fail_status;
      end else if (start) begin
        field <= F_SOF;
        sr    <= {h_id, h_rtr, 2'b00, h_dlc, h_data};
      end else if (step) begin
        case (field)
          F_SOF: begin
            field <= F_ID;
            cnt   <= CNT_W'(ID_W - 1);
          end
          F_ID: begin
            sr <= sr << 1;
            if (cnt == '0) field <= F_RTR;
            else           cnt   <= cnt - 1'b1;
          end
          F_RTR: begin
            sr    <= sr << 1;
            field <= F_CTRL;
            cnt   <= CNT_W'(2 + DLC_W - 1);
          end
          F_CTRL: begin
            sr <= sr << 1;
            if (cnt == '0) begin
              if (h_nbytes == '0) begin
                field <= F_CRC;
                cnt   <= CNT_W'(CRC_W - 1);
              end else begin
                field <= F_DATA;
                cnt   <= data_bits - CNT_W'(1);
              end
            end else cnt <= cnt - 1'b1;
          end
          F_DATA: begin
            sr <= sr << 1;
            if (cnt == '0) begin
              field <= F_CRC;
              cnt   <= CNT_W'(CRC_W - 1);
            end else cnt <= cnt - 1'b1;
          end
          F_CRC: begin
            if (cnt == '0) field <= F_CRCDEL;
            else           cnt   <= cnt - 1'b1;
          end
          F_CRCDEL: field <= F_ACK;
          F_ACK:    field <= F_ACKDEL;
          F_ACKDEL: begin
            field <= F_EOF;
            cnt   <= CNT_W'(EOF_LEN - 1);
          end
          F_EOF: begin
            if (cnt == '0) begin
              field       <= F_IDLE;
              done_valid  <= 1'b1;
              done_status <= TX_OK;
            end else cnt <= cnt - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_ATTEMPT_OPENS_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !tx_bit); // R3
  AST_STUFF_WINDOW_OPENS_ON_SOF: assert property (@(posedge clk) disable iff (!rst_n) $rose(stuffable) |-> !tx_bit && busy); // R7
  AST_ARB_LOSS_IN_ARB_FIELD: assert property (@(posedge clk) disable iff (!rst_n) done_valid && done_status == TX_ARB_LOST |-> $past(field) inside {F_ID, F_RTR}); // R8
  AST_ACK_ERR_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n) done_valid && done_status == TX_ACK_ERR |-> $past(field) == F_ACK); // R10
  AST_OK_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n) done_valid && done_status == TX_OK |-> $past(field) == F_EOF && !busy); // R11
  AST_SILENT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done_valid |-> tx_bit && !stuffable); // R8
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int EOF_LEN   = 7,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int NB_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_rtr,
  input  logic [DLC_W-1:0]  req_dlc,
  input  logic [DATA_W-1:0] req_data,
  input  logic              bit_tick,
  input  logic              bus_bit,
  input  logic              bus_idle,
  output logic              tx_bit,
  output logic              tx_stuffable,
  output logic              tx_busy,
  output logic              done_valid,
  output logic [1:0]        done_status
);
  logic              pending;
  logic [ID_W-1:0]   h_id;
  logic              h_rtr;
  logic [DLC_W-1:0]  h_dlc;
  logic [DATA_W-1:0] h_data;
  logic [NB_W-1:0]   h_nbytes;
  logic              success;
  logic              fail;
  txst_e             fail_status;
  txst_e             st;
  fld_e              field;
  logic              crc_clr, crc_feed, crc_shift, crc_msb;

  assign success     = done_valid && (st == TX_OK);
  assign done_status = st;

  can_tx_req_hold #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)) hold_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .req_dlc(req_dlc), .req_data(req_data),
    .success(success), .pending(pending), .h_id(h_id), .h_rtr(h_rtr),
    .h_dlc(h_dlc), .h_data(h_data), .h_nbytes(h_nbytes)
  );

  can_tx_mon mon_i (
    .tick(bit_tick), .field(field), .tx_bit(tx_bit), .bus_bit(bus_bit),
    .fail(fail), .fail_status(fail_status)
  );

  can_tx_crc crc_i (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .feed_en(crc_feed),
    .feed_bit(tx_bit), .shift_en(crc_shift), .msb(crc_msb)
  );

  can_tx_seq #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES), .EOF_LEN(EOF_LEN)) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .start_ok(pending && bus_idle),
    .h_id(h_id), .h_rtr(h_rtr), .h_dlc(h_dlc), .h_data(h_data), .h_nbytes(h_nbytes),
    .fail(fail), .fail_status(fail_status), .crc_msb(crc_msb),
    .field(field), .busy(tx_busy), .tx_bit(tx_bit), .stuffable(tx_stuffable),
    .crc_clr(crc_clr), .crc_feed(crc_feed), .crc_shift(crc_shift),
    .done_valid(done_valid), .done_status(st)
  );

  AST_NO_START_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> $past(pending) && $past(bus_idle)); // R3
endmodule

// File: tb/can_frame_tx_tb_top.sv
module can_frame_tx_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [10:0] req_id = '0;
  logic req_rtr = 0;
  logic [3:0] req_dlc = '0;
  logic [63:0] req_data = '0;
  logic bit_tick = 0;
  logic bus_bit = 1;
  logic bus_idle = 0;
  logic tx_bit, tx_stuffable, tx_busy, done_valid;
  logic [1:0] done_status;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  can_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .req_dlc(req_dlc), .req_data(req_data),
    .bit_tick(bit_tick), .bus_bit(bus_bit), .bus_idle(bus_idle),
    .tx_bit(tx_bit), .tx_stuffable(tx_stuffable), .tx_busy(tx_busy),
    .done_valid(done_valid), .done_status(done_status)
  );

  typedef struct packed {
    logic [10:0] id;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [1:0]  mode;   // 0 acked, 1 no ack, 2 rival arbitration, 3 forced bit flip
    logic [10:0] prm;    // rival identifier or flipped bit index
    logic [1:0]  exp_st;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{11'h123, 1'b0, 4'd2,  64'hABCD_0000_0000_0000, 2'd0, 11'd0,     2'd0},
    '{11'h7FF, 1'b1, 4'd4,  64'h1122_3344_5566_7788, 2'd0, 11'd0,     2'd0},
    '{11'h000, 1'b0, 4'd15, 64'h0123_4567_89AB_CDEF, 2'd0, 11'd0,     2'd0},
    '{11'h456, 1'b0, 4'd1,  64'h5A00_0000_0000_0000, 2'd1, 11'd0,     2'd3},
    '{11'h2AA, 1'b0, 4'd3,  64'hFFEE_DD00_0000_0000, 2'd2, 11'h2A8,   2'd1},
    '{11'h100, 1'b0, 4'd2,  64'h8001_0000_0000_0000, 2'd3, 11'd22,    2'd2},
    '{11'h055, 1'b0, 4'd0,  64'h0,                   2'd3, 11'd36,    2'd2}
  };

  logic exp_bits [0:127];
  int   exp_len;
  int   stuff_end;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [10:0] id, input logic rtr, input logic [3:0] dlc, input logic [63:0] data);
    int nb, k;
    logic [14:0] c;
    logic fb;
    nb = rtr ? 0 : (dlc > 8 ? 8 : int'(dlc));
    k = 0;
    exp_bits[k++] = 1'b0;
    for (int i = 10; i >= 0; i--) exp_bits[k++] = id[i];
    exp_bits[k++] = rtr;
    exp_bits[k++] = 1'b0;
    exp_bits[k++] = 1'b0;
    for (int i = 3; i >= 0; i--) exp_bits[k++] = dlc[i];
    for (int i = 0; i < nb * 8; i++) exp_bits[k++] = data[63 - i];
    c = '0;
    for (int i = 0; i < k; i++) begin
      fb = c[14] ^ exp_bits[i];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) exp_bits[k++] = c[i];
    stuff_end = k;
    for (int i = 0; i < 10; i++) exp_bits[k++] = 1'b1;
    exp_len = k;
  endtask

  task automatic tick_bit(input logic b, output logic dv, output logic [1:0] ds);
    @(negedge clk);
    bus_bit = b;
    bit_tick = 1;
    @(negedge clk);
    bit_tick = 0;
    dv = done_valid;
    ds = done_status;
    @(negedge clk);
    bus_bit = 1;
  endtask

  task automatic idle_ticks(input string req);
    logic dv;
    logic [1:0] ds;
    bus_idle = 0;
    for (int i = 0; i < 3; i++) tick_bit(1'b1, dv, ds);
    chk(tx_bit === 1'b1 && tx_busy === 1'b0 && dv === 1'b0, req, {tx_bit, tx_busy, dv}, 3'b100);
    chk(req_ready === 1'b0, {req, " frame still held"}, req_ready, 0);
  endtask

  task automatic run_attempt(input vec_t v, input int mode, input int exp_st, input string tag);
    logic dv;
    logic [1:0] ds;
    logic b;
    int bad_bit, bad_stuff, end_k;
    bit got;
    build(v.id, v.rtr, v.dlc, v.data);
    bus_idle = 1;
    tick_bit(1'b1, dv, ds);
    bus_idle = 0;
    bad_bit = 0; bad_stuff = 0; got = 0; end_k = -1;
    for (int k = 0; k < exp_len; k++) begin
      if (tx_bit !== exp_bits[k]) bad_bit++;
      if (tx_stuffable !== (k < stuff_end)) bad_stuff++;
      b = tx_bit;
      if (k == stuff_end + 1) b = (mode == 1) ? 1'b1 : 1'b0;
      if (mode == 2 && k >= 1 && k <= 11) b = tx_bit & v.prm[11 - k];
      if (mode == 2 && k == 12) b = 1'b0;
      if (mode == 3 && k == int'(v.prm)) b = ~tx_bit;
      tick_bit(b, dv, ds);
      if (dv) begin
        got = 1; end_k = k;
        break;
      end
    end
    chk(bad_bit == 0, {tag, " R4 R5 R6 bit stream"}, bad_bit, 0);
    chk(bad_stuff == 0, {tag, " R7 stuffable window"}, bad_stuff, 0);
    chk(got && ds == 2'(exp_st), {tag, " R8 R9 R10 R11 completion status"}, {got, ds}, {1'b1, 2'(exp_st)});
    if (exp_st == 0) chk(end_k == exp_len - 1, {tag, " R11 completes on last EOF bit"}, end_k, exp_len - 1);
    chk(tx_bit === 1'b1 && tx_busy === 1'b0, {tag, " R8 silent after attempt"}, {tx_bit, tx_busy}, 2'b10);
    if (exp_st == 0) chk(req_ready === 1'b1, {tag, " R11 ready after success"}, req_ready, 1);
    else             chk(req_ready === 1'b0, {tag, " R12 frame kept for retry"}, req_ready, 0);
  endtask

  task automatic submit(input vec_t v);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", req_ready, 1);
    req_valid = 1; req_id = v.id; req_rtr = v.rtr; req_dlc = v.dlc; req_data = v.data;
    @(negedge clk);
    req_valid = 0;
    req_id = ~v.id; req_data = ~v.data;
    chk(req_ready === 1'b0, "R2 ready drops on accept", req_ready, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_bit === 1'b1 && tx_stuffable === 1'b0 && tx_busy === 1'b0 && done_valid === 1'b0,
        "R1 reset outputs", {tx_bit, tx_stuffable, tx_busy, done_valid}, 4'b1000);
    chk(req_ready === 1'b1, "R1 reset ready", req_ready, 1);

    for (int i = 0; i < 7; i++) begin
      submit(VECS[i]);
      idle_ticks("R3 no start while bus busy");
      run_attempt(VECS[i], int'(VECS[i].mode), int'(VECS[i].exp_st), $sformatf("vec%0d", i));
      if (VECS[i].exp_st != 0) begin
        idle_ticks("R12 retry waits for idle");
        run_attempt(VECS[i], 0, 0, $sformatf("vec%0d retry R12", i));
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule